// File: doc/BRIEF.md
# Pixel Thermometer Encoder Stream

This block turns a stream of 8-bit unsigned image pixels into 64-bit thermometer-coded words for the input layer of a binary neural network. Each pixel is quantized with a fixed step of 8. The quotient is rounded to the nearest integer and capped at 32. The block then emits a word whose upper 32 bits carry that many ones, packed against bit 63. The lower 32 bits are always zero. Brighter pixels therefore light more bits, and a black pixel gives an all-zero word.

Both sides use a valid/ready handshake, with one pixel accepted per cycle. The block counts the position of every accepted pixel within a frame of 3 channels by 32 rows by 32 columns. Column changes fastest, then row, then channel. Each output word carries its channel, row and column. The 3072nd word of a frame carries a last marker, and the position counters then wrap to the start of the next frame. A single output register holds the word while the consumer stalls, and no new pixel is taken until the held word leaves.

Top module: `pte_enc`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and the position counters return to channel 0, row 0, column 0. The first pixel accepted after reset is tagged (0,0,0).
- R2: The level is min(32, floor((pixel + 4) / 8)), and the output word holds exactly that many ones. Examples: pixels 0, 3, 4, 11, 12, 100, 251, 252 and 255 give levels 0, 0, 1, 1, 2, 13, 31, 32 and 32. Pixel 0 gives an all-zero word.
- R3: The ones of every output word form one contiguous run that starts at bit 63 and extends downward. No bit below the run is set.
- R4: Bits 31:0 of every output word are 0.
- R5: in_ready_o equals (!out_valid_o || out_ready_i). A pixel accepted at a clock edge appears on out_valid_o/out_word_o immediately after that edge.
- R6: While out_valid_o is 1 and out_ready_i is 0, the word, last flag and tags stay unchanged at the next edge, and in_ready_o is 0.
- R7: The sequence of words leaving through the output handshake equals the sequence of accepted pixels, each encoded once. Nothing is dropped, duplicated or reordered.
- R8: The output tags give the position of the pixel in the frame. Column 0..31 counts fastest, then row 0..31, then channel 0..2.
- R9: out_last_o is 1 exactly on the word at channel 2, row 31, column 31, which is the 3072nd word of a frame. The next word is tagged (0,0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Block can take a pixel this cycle |
| in_pixel_i | input | 8 | Unsigned pixel value |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer takes the word this cycle |
| out_word_o | output | 64 | Thermometer-coded word |
| out_last_o | output | 1 | Final word of a frame |
| out_chan_o | output | 2 | Channel of the word |
| out_row_o | output | 5 | Row of the word |
| out_col_o | output | 5 | Column of the word |

## Verification
A wrong quantizer or code generator shows on the very next output word as a wrong count of ones, a broken run or a set padding bit. A corrupted position counter shows as a wrong tag on the next accepted pixel. The same fault misplaces out_last_o on the frame boundary, so it is seen within one frame at worst. Faults in the holding register or in the ready logic show during the first stall: the word changes while out_ready_i is low, or a pixel vanishes or repeats. A per-cycle comparison against an expected queue catches this at once.

// File: rtl/pte_pkg.sv
package pte_pkg;
  localparam int unsigned PIX_W_D     = 8;
  localparam int unsigned STEP_LOG2_D = 3;
  localparam int unsigned LEVELS_D    = 32;
  localparam int unsigned WORD_W_D    = 64;
  localparam int unsigned CHANNELS_D  = 3;
  localparam int unsigned ROWS_D      = 32;
  localparam int unsigned COLS_D      = 32;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pte_quant.sv
module pte_quant #(
  parameter int unsigned PIX_W     = pte_pkg::PIX_W_D,
  parameter int unsigned STEP_LOG2 = pte_pkg::STEP_LOG2_D,
  parameter int unsigned LEVELS    = pte_pkg::LEVELS_D,
  localparam int unsigned LVL_W    = $clog2(LEVELS + 1)
) (
  input  logic [PIX_W-1:0] pix_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int unsigned SUM_W = PIX_W + 1;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (STEP_LOG2 - 1);
  localparam logic [SUM_W-1:0] SAT  = SUM_W'(LEVELS);

  logic [SUM_W-1:0] sum, quo;

  // round to nearest, then cap at the level count
  always_comb begin
    sum = {1'b0, pix_i} + HALF;
    quo = sum >> STEP_LOG2;
    level_o = (quo > SAT) ? LVL_W'(LEVELS) : LVL_W'(quo);
  end
endmodule

// File: rtl/pte_therm.sv
module pte_therm #(
  parameter int unsigned LEVELS = pte_pkg::LEVELS_D,
  parameter int unsigned WORD_W = pte_pkg::WORD_W_D,
  localparam int unsigned LVL_W = $clog2(LEVELS + 1)
) (
  input  logic [LVL_W-1:0]  level_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar i = 0; i < LEVELS; i++) begin : g_bit
    assign word_o[WORD_W-1-i] = (level_i > LVL_W'(i));
  end

  if (WORD_W > LEVELS) begin : g_pad
    assign word_o[WORD_W-LEVELS-1:0] = '0;
  end
endmodule

// File: rtl/pte_pos.sv
module pte_pos #(
  parameter int unsigned CHANNELS = pte_pkg::CHANNELS_D,
  parameter int unsigned ROWS     = pte_pkg::ROWS_D,
  parameter int unsigned COLS     = pte_pkg::COLS_D,
  localparam int unsigned CH_W    = pte_pkg::idx_w(CHANNELS),
  localparam int unsigned ROW_W   = pte_pkg::idx_w(ROWS),
  localparam int unsigned COL_W   = pte_pkg::idx_w(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic col_end, row_end, chan_end;

  assign col_end  = (col_o  == COL_W'(COLS - 1));
  assign row_end  = (row_o  == ROW_W'(ROWS - 1));
  assign chan_end = (chan_o == CH_W'(CHANNELS - 1));
  assign last_o   = col_end && row_end && chan_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o  <= '0;
      row_o  <= '0;
      chan_o <= '0;
    end else if (adv_i) begin
      col_o <= col_end ? '0 : col_o + 1'b1;
      if (col_end) begin
        row_o <= row_end ? '0 : row_o + 1'b1;
        if (row_end) chan_o <= chan_end ? '0 : chan_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pte_enc.sv
module pte_enc #(
  parameter int unsigned PIX_W     = pte_pkg::PIX_W_D,
  parameter int unsigned STEP_LOG2 = pte_pkg::STEP_LOG2_D,
  parameter int unsigned LEVELS    = pte_pkg::LEVELS_D,
  parameter int unsigned WORD_W    = pte_pkg::WORD_W_D,
  parameter int unsigned CHANNELS  = pte_pkg::CHANNELS_D,
  parameter int unsigned ROWS      = pte_pkg::ROWS_D,
  parameter int unsigned COLS      = pte_pkg::COLS_D,
  localparam int unsigned LVL_W    = $clog2(LEVELS + 1),
  localparam int unsigned CH_W     = pte_pkg::idx_w(CHANNELS),
  localparam int unsigned ROW_W    = pte_pkg::idx_w(ROWS),
  localparam int unsigned COL_W    = pte_pkg::idx_w(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  in_pixel_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic              out_last_o,
  output logic [CH_W-1:0]   out_chan_o,
  output logic [ROW_W-1:0]  out_row_o,
  output logic [COL_W-1:0]  out_col_o
);
  logic [LVL_W-1:0]  level;
  logic [WORD_W-1:0] code;
  logic [CH_W-1:0]   pos_chan;
  logic [ROW_W-1:0]  pos_row;
  logic [COL_W-1:0]  pos_col;
  logic              pos_last;
  logic              accept;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  pte_quant #(.PIX_W(PIX_W), .STEP_LOG2(STEP_LOG2), .LEVELS(LEVELS)) i_quant (
    .pix_i   (in_pixel_i),
    .level_o (level)
  );

  pte_therm #(.LEVELS(LEVELS), .WORD_W(WORD_W)) i_therm (
    .level_i (level),
    .word_o  (code)
  );

  pte_pos #(.CHANNELS(CHANNELS), .ROWS(ROWS), .COLS(COLS)) i_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .chan_o (pos_chan),
    .row_o  (pos_row),
    .col_o  (pos_col),
    .last_o (pos_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // payload needs no reset: qualified by out_valid_o
  always_ff @(posedge clk_i) begin
    if (accept) begin
      out_word_o <= code;
      out_last_o <= pos_last;
      out_chan_o <= pos_chan;
      out_row_o  <= pos_row;
      out_col_o  <= pos_col;
    end
  end
endmodule

// File: rtl/pte_checker.sv
module pte_checker #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned LEVELS   = 32,
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned CHANNELS = 3,
  parameter int unsigned ROWS     = 32,
  parameter int unsigned COLS     = 32,
  parameter int unsigned CH_W     = 2,
  parameter int unsigned ROW_W    = 5,
  parameter int unsigned COL_W    = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [PIX_W-1:0]  in_pixel_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_word_o,
  input logic              out_last_o,
  input logic [CH_W-1:0]   out_chan_o,
  input logic [ROW_W-1:0]  out_row_o,
  input logic [COL_W-1:0]  out_col_o
);
  localparam int unsigned PAD = WORD_W - LEVELS;

  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> !out_valid_o);

  p_zero_pixel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_pixel_i == '0) |=> (out_word_o == '0));

  p_level_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones(out_word_o) <= LEVELS));

  p_contiguous_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_word_o[WORD_W-2:0] & ~out_word_o[WORD_W-1:1]) == '0));

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_word_o[PAD-1:0] == '0));

  p_accept_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  p_hold_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_word_o)
      && $stable(out_last_o) && $stable(out_col_o));

  p_stall_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_last_position_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> (out_chan_o == CH_W'(CHANNELS - 1))
      && (out_row_o == ROW_W'(ROWS - 1)) && (out_col_o == COL_W'(COLS - 1)));
endmodule

bind pte_enc pte_checker #(
  .PIX_W(PIX_W), .LEVELS(LEVELS), .WORD_W(WORD_W), .CHANNELS(CHANNELS),
  .ROWS(ROWS), .COLS(COLS), .CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W)
) i_chk (.*);

// File: tb/test_pte_enc.sv
module test_pte_enc;
  localparam int FRAME = 3072;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_pixel_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [63:0] out_word_o;
  logic        out_last_o;
  logic [1:0]  out_chan_o;
  logic [4:0]  out_row_o;
  logic [4:0]  out_col_o;

  always #4 clk_i = ~clk_i;

  pte_enc i_pte_enc (.*);

  int tests = 0, fails = 0;
  logic [63:0] q_word[$];
  int          q_pos[$];
  int          pos_model = 0;
  int          accepted = 0;
  int          lasts = 0;
  bit          pending = 0;
  bit          prev_stall = 0;
  logic [63:0] prev_word = '0;

  function automatic logic [63:0] ref_word(int p);
    int lvl;
    logic [63:0] w;
    lvl = (p + 4) / 8;
    if (lvl > 32) lvl = 32;
    w = '0;
    for (int i = 0; i < lvl; i++) w[63-i] = 1'b1;
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(bit v, int pix, bit rdy);
    int p;
    @(negedge clk_i);
    if (!pending) begin
      in_valid_i = v;
      in_pixel_i = 8'(pix);
    end
    out_ready_i = rdy;
    #1;
    check(out_valid_o == (q_word.size() > 0), "R7 valid", 64'(out_valid_o), 64'(q_word.size()));
    check(in_ready_o == (!out_valid_o || out_ready_i), "R5 ready", 64'(in_ready_o),
          64'(!out_valid_o || out_ready_i));
    if (prev_stall) check(out_word_o == prev_word, "R6 hold", out_word_o, prev_word);
    if (out_valid_o && q_word.size() > 0) begin
      p = q_pos[0];
      check(out_word_o == q_word[0], "R2/R3/R4 word", out_word_o, q_word[0]);
      check({out_chan_o, out_row_o, out_col_o} == 12'(p), "R8 tags",
            64'({out_chan_o, out_row_o, out_col_o}), 64'(p));
      check(out_last_o == (p == FRAME - 1), "R9 last", 64'(out_last_o), 64'(p == FRAME - 1));
    end
    prev_stall = out_valid_o && !out_ready_i;
    prev_word  = out_word_o;
    if (out_valid_o && out_ready_i && q_word.size() > 0) begin
      if (out_last_o) lasts++;
      void'(q_word.pop_front());
      void'(q_pos.pop_front());
    end
    if (in_valid_i && in_ready_o) begin
      q_word.push_back(ref_word(int'(in_pixel_i)));
      q_pos.push_back(pos_model);
      pos_model = (pos_model + 1) % FRAME;
      accepted++;
    end
    pending = in_valid_i && !in_ready_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    #1;
    check(out_valid_o == 1'b0, "R1 reset valid", 64'(out_valid_o), 64'd0);
    check(in_ready_o == 1'b1, "R1 reset ready", 64'(in_ready_o), 64'd1);
    q_word.delete();
    q_pos.delete();
    pos_model = 0;
    pending = 0;
    prev_stall = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    int dir[9] = '{0, 3, 4, 11, 12, 100, 251, 252, 255};
    do_reset();
    // R2 directed levels 0,0,1,1,2,13,31,32,32
    foreach (dir[i]) cycle(1'b1, dir[i], 1'b1);
    cycle(1'b0, 0, 1'b1);
    // R6 stall with a held word
    cycle(1'b1, 200, 1'b0);
    cycle(1'b1, 40, 1'b0);
    cycle(1'b1, 40, 1'b0);
    cycle(1'b0, 0, 1'b1);
    cycle(1'b0, 0, 1'b1);
    // R1 mid-frame reset restarts position at (0,0,0)
    do_reset();
    accepted = 0;
    lasts = 0;
    while (accepted < 2 * FRAME + 50)
      cycle($urandom_range(99, 0) < 80, int'($urandom_range(255, 0)),
            $urandom_range(99, 0) < 70);
    repeat (4) cycle(1'b0, 0, 1'b1);
    check(q_word.size() == 0, "R7 drained", 64'(q_word.size()), 64'd0);
    check(lasts == 2, "R9 frame count", 64'(lasts), 64'd2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule